// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the vector-length setup instruction of a vector extension that runs on the scalar register files. Each issued 32-bit instruction word arrives with the value of its RA operand, the count register and the current vector state: maximum length, current length and a vertical-first flag. One clock later the unit presents the new vector state, an optional write-back of a general register and an optional update of condition field 0.

The instruction carries a 7-bit immediate biased by one, so immediate lengths run from 1 to 128. The length source is the immediate, RA or the count register, chosen by whether the RA and RT register numbers are zero. The chosen length is clamped against the maximum length as an unsigned 64-bit compare. The condition field describes the resulting length and whether a clamp happened. It does not describe the RT value.

Top module: `vlcfg_unit`

## Requirements
- R1: An issue is accepted only when instruction bits [31:26] equal parameter PRI_OP (default 22) and bits [5:1] equal 5'b11011. Results appear with outValid one cycle after an accepted issue. A non-matching issue leaves outValid, rtWe and crWe low and stateOut unchanged.
- R2: The immediate is bits [15:9] plus one. An immediate-sourced length is therefore 1 to 128 and never zero.
- R3: When bit 8 (set-max) is 1, the maximum length becomes the immediate. When bit 7 (set-length) is also 1, the length is clamped against this new maximum.
- R4: With set-length=1, RA field (bits [20:16]) = 0 and RT field (bits [25:21]) = 0, the length becomes MIN(max, immediate) and rtWe stays low.
- R5: With set-length=1, RA field = 0 and RT field non-zero, the length becomes MIN(max, count register), and that value is written to RT.
- R6: With set-length=1 and RA field non-zero, the length becomes MIN(max, RA value), compared as unsigned 64-bit. RT is written only if the RT field is non-zero.
- R7: With set-length=0 and set-max=0, length and maximum are unchanged, and a non-zero RT field receives the current length. With set-length=0 and set-max=1, rtWe stays low.
- R8: Bit 6 is copied into the vertical-first flag, stateOut[16].
- R9: When bit 0 (Rc) is 1, crWe is raised with crField = {LT=0, GT=(length!=0), EQ=(length==0), SO=clamped}, bits [3:0] in that order. When Rc is 0, crWe stays low.
- R10: rtAddr equals the RT field. rtData is the 8-bit length zero-extended to 64 bits.
- R11: During and right after reset, outValid, rtWe and crWe are 0 and stateOut is 0. The state packs as {vertFirst[16], maxLen[15:8], curLen[7:0]}.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| raVal | input | 64 | Value of register RA |
| ctrVal | input | 64 | Count register value |
| stateIn | input | 17 | Current vector state |
| outValid | output | 1 | Results valid |
| stateOut | output | 17 | Updated vector state |
| rtWe | output | 1 | RT write enable |
| rtAddr | output | 5 | RT register number |
| rtData | output | 64 | RT write data |
| crWe | output | 1 | Condition field 0 write enable |
| crField | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench drives requests wider than 8 bits with a small low byte, such as 2^32+5. A design that truncates before comparing would produce 5 instead of clamping. It sets the maximum and the length in one instruction with a request above the old maximum; a design that clamps against the old maximum gives the wrong length. It sources a zero length from the count register, so a design that drives the condition bits from RT or from the immediate shows the wrong EQ and GT. It also checks immediate 0 mapping to 1, register-0 cases suppressing write-back, and foreign opcodes leaving the state untouched.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int LEN_W = 8;
  localparam int IMM_W = 7;
  localparam int IDX_W = 5;
  localparam logic [4:0] EXT_OP = 5'b11011;

  typedef struct packed {
    logic             vertFirst;
    logic [LEN_W-1:0] maxLen;
    logic [LEN_W-1:0] curLen;
  } vecState_t;

  localparam int STATE_W = $bits(vecState_t);

  typedef enum logic [1:0] {SRC_IMM, SRC_CTR, SRC_RA} lenSrc_t;

  typedef struct packed {
    logic             hit;
    logic             setMax;
    logic             setLen;
    lenSrc_t          lenSrc;
    logic             writeRt;
    logic             writeCr;
    logic             vfBit;
    logic [IDX_W-1:0] rtIdx;
    logic [LEN_W-1:0] immVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
#(
  parameter logic [5:0] PRI_OP = 6'd22
) (
  input  logic        issueValid,
  input  logic [31:0] instr,
  output ctrlStrobe_t ctl
);
  logic [5:0]       opField;
  logic [IDX_W-1:0] rtField;
  logic [IDX_W-1:0] raField;
  logic [IMM_W-1:0] sviField;
  logic [4:0]       xoField;
  logic             msBit, vsBit, vfBit, rcBit, match;

  assign opField  = instr[31:26];
  assign rtField  = instr[25:21];
  assign raField  = instr[20:16];
  assign sviField = instr[15:9];
  assign msBit    = instr[8];
  assign vsBit    = instr[7];
  assign vfBit    = instr[6];
  assign xoField  = instr[5:1];
  assign rcBit    = instr[0];
  assign match    = issueValid && (opField == PRI_OP) && (xoField == EXT_OP);

  always_comb begin
    ctl = '0;
    ctl.hit    = match;
    ctl.setMax = match && msBit;
    ctl.setLen = match && vsBit;
    ctl.vfBit  = vfBit;
    ctl.rtIdx  = rtField;
    ctl.immVal = {1'b0, sviField} + 1'b1;
    if (raField != '0)      ctl.lenSrc = SRC_RA;
    else if (rtField != '0) ctl.lenSrc = SRC_CTR;
    else                    ctl.lenSrc = SRC_IMM;
    ctl.writeRt = match && (rtField != '0) && (vsBit || !msBit);
    ctl.writeCr = match && rcBit;
  end
endmodule

// File: rtl/vlcfg_dpath.sv
module vlcfg_dpath
  import vlcfg_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctl,
  input  logic [REG_W-1:0]   raVal,
  input  logic [REG_W-1:0]   ctrVal,
  input  vecState_t          stateIn,
  output logic               outValid,
  output vecState_t          stateOut,
  output logic               rtWe,
  output logic [IDX_W-1:0]   rtAddr,
  output logic [REG_W-1:0]   rtData,
  output logic               crWe,
  output logic [3:0]         crField
);
  localparam int PAD_W = REG_W - LEN_W;

  logic [REG_W-1:0] reqVal;
  logic [LEN_W-1:0] nextMax, nextLen;
  logic             overMax, clampHit;

  always_comb begin
    case (ctl.lenSrc)
      SRC_RA:  reqVal = raVal;
      SRC_CTR: reqVal = ctrVal;
      default: reqVal = {{PAD_W{1'b0}}, ctl.immVal};
    endcase
  end

  assign nextMax  = ctl.setMax ? ctl.immVal : stateIn.maxLen;
  assign overMax  = reqVal > {{PAD_W{1'b0}}, nextMax};
  assign clampHit = ctl.setLen && overMax;
  assign nextLen  = !ctl.setLen ? stateIn.curLen
                  : (overMax ? nextMax : reqVal[LEN_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      stateOut <= '0;
      rtWe     <= 1'b0;
      rtAddr   <= '0;
      rtData   <= '0;
      crWe     <= 1'b0;
      crField  <= '0;
    end else begin
      outValid <= ctl.hit;
      rtWe     <= ctl.writeRt;
      crWe     <= ctl.writeCr;
      if (ctl.hit) begin
        stateOut <= '{vertFirst: ctl.vfBit, maxLen: nextMax, curLen: nextLen};
        rtAddr   <= ctl.rtIdx;
        rtData   <= {{PAD_W{1'b0}}, nextLen};
        crField  <= {1'b0, nextLen != '0, nextLen == '0, clampHit};
      end
    end
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int         REG_W  = 64,
  parameter logic [5:0] PRI_OP = 6'd22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [31:0]        instr,
  input  logic [REG_W-1:0]   raVal,
  input  logic [REG_W-1:0]   ctrVal,
  input  logic [STATE_W-1:0] stateIn,
  output logic               outValid,
  output logic [STATE_W-1:0] stateOut,
  output logic               rtWe,
  output logic [IDX_W-1:0]   rtAddr,
  output logic [REG_W-1:0]   rtData,
  output logic               crWe,
  output logic [3:0]         crField
);
  ctrlStrobe_t ctl;
  vecState_t   stateNew;

  vlcfg_ctrl #(.PRI_OP(PRI_OP)) u_ctrl (
    .issueValid(issueValid),
    .instr(instr),
    .ctl(ctl)
  );

  vlcfg_dpath #(.REG_W(REG_W)) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .raVal(raVal),
    .ctrVal(ctrVal),
    .stateIn(vecState_t'(stateIn)),
    .outValid(outValid),
    .stateOut(stateNew),
    .rtWe(rtWe),
    .rtAddr(rtAddr),
    .rtData(rtData),
    .crWe(crWe),
    .crField(crField)
  );

  assign stateOut = stateNew;
endmodule

// File: rtl/vlcfg_checker.sv
module vlcfg_checker #(
  parameter int         REG_W  = 64,
  parameter logic [5:0] PRI_OP = 6'd22
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic [31:0]      instr,
  input logic             outValid,
  input logic [16:0]      stateOut,
  input logic             rtWe,
  input logic [REG_W-1:0] rtData,
  input logic             crWe,
  input logic [3:0]       crField
);
  assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (instr[31:26] != PRI_OP || instr[5:1] != 5'b11011) |=> !outValid);

  assert_we_needs_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rtWe || crWe) |-> outValid);

  assert_imm_max_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[8]) |-> stateOut[15:8] != 8'd0);

  assert_len_within_max_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[7]) |-> stateOut[7:0] <= stateOut[15:8]);

  assert_zero_regs_no_wb_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(instr[7]) && $past(instr[25:16] == 10'd0) |-> !rtWe);

  assert_vf_copied_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> stateOut[16] == $past(instr[6]));

  assert_cr_shape_R9: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> !crField[3] && (crField[2] != crField[1]));

  assert_cr_eq_len_R9: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> crField[1] == (stateOut[7:0] == 8'd0));

  assert_wb_zext_R10: assert property (@(posedge clk) disable iff (!rstN)
    rtWe |-> rtData == {{(REG_W-8){1'b0}}, stateOut[7:0]});
endmodule

bind vlcfg_unit vlcfg_checker #(.REG_W(REG_W), .PRI_OP(PRI_OP)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
  .outValid(outValid), .stateOut(stateOut), .rtWe(rtWe), .rtData(rtData),
  .crWe(crWe), .crField(crField)
);

// File: tb/vlcfg_unit_bench.sv
module vlcfg_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] raVal = '0, ctrVal = '0;
  logic [16:0] stateIn = '0;
  logic        outValid, rtWe, crWe;
  logic [16:0] stateOut;
  logic [4:0]  rtAddr;
  logic [63:0] rtData;
  logic [3:0]  crField;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  logic [16:0] expState = '0;
  logic        expValid, expRtWe, expCrWe;
  logic [63:0] expRtData;
  logic [3:0]  expCr;

  always #10 clk = ~clk;

  vlcfg_unit u_vlcfg_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
    .raVal(raVal), .ctrVal(ctrVal), .stateIn(stateIn),
    .outValid(outValid), .stateOut(stateOut), .rtWe(rtWe), .rtAddr(rtAddr),
    .rtData(rtData), .crWe(crWe), .crField(crField)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int op, int rt, int ra, int svi,
                                     bit ms, bit vs, bit vf, int xo, bit rc);
    return {op[5:0], rt[4:0], ra[4:0], svi[6:0], ms, vs, vf, xo[4:0], rc};
  endfunction

  // Behavioural reference: one issue, results sampled one cycle later.
  task automatic issue(string tag, int rt, int ra, int svi, bit ms, bit vs,
                       bit vf, bit rc, longint unsigned raV, longint unsigned ctrV,
                       int curMax, int curLen, int op = 22, int xo = 27);
    longint unsigned req, mx, ln;
    bit accepted, clamped;
    instr = mk(op, rt, ra, svi, ms, vs, vf, xo, rc);
    raVal = raV;
    ctrVal = ctrV;
    stateIn = {1'b0, curMax[7:0], curLen[7:0]};
    issueValid = 1'b1;
    accepted = (op == 22) && (xo == 27);
    mx = ms ? longint'(svi + 1) : longint'(curMax);
    if (ra != 0)      req = raV;
    else if (rt != 0) req = ctrV;
    else              req = longint'(svi + 1);
    clamped = vs && (req > mx);
    ln = !vs ? longint'(curLen) : (clamped ? mx : req);
    expValid = accepted;
    expRtWe = accepted && rt != 0 && (vs || !ms);
    expCrWe = accepted && rc;
    if (accepted) begin
      expState = {vf, mx[7:0], ln[7:0]};
      expRtData = ln;
      expCr = {1'b0, ln != 0, ln == 0, clamped};
    end
    @(posedge clk);
    @(negedge clk);
    issueValid = 1'b0;
    check(tag, "outValid", outValid, expValid);
    check(tag, "stateOut", stateOut, expState);
    check(tag, "rtWe", rtWe, expRtWe);
    check(tag, "crWe", crWe, expCrWe);
    if (expRtWe) begin
      check(tag, "rtAddr", rtAddr, rt);
      check(tag, "rtData", rtData, expRtData);
    end
    if (expCrWe) check(tag, "crField", crField, expCr);
  endtask

  task automatic idle(string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, "idle outValid", outValid, 0);
    check(tag, "idle stateOut", stateOut, expState);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset outValid", outValid, 0);
    check("R11", "reset stateOut", stateOut, 0);
    check("R11", "reset rtWe", rtWe, 0);
    check("R11", "reset crWe", crWe, 0);
    rstN = 1'b1;
    idle("R11");

    // R4: immediate source, register 0 on both sides
    issue("R4", 0, 0, 7, 0, 1, 0, 1, 0, 0, 16, 3);
    issue("R4", 0, 0, 31, 0, 1, 0, 1, 0, 0, 16, 3);
    // R2: bias, 0 -> 1 and 127 -> 128
    issue("R2", 0, 0, 0, 1, 0, 0, 0, 0, 0, 50, 4);
    issue("R2", 0, 0, 127, 1, 1, 0, 1, 0, 0, 2, 1);
    // R3: new maximum used for the clamp
    issue("R3", 0, 0, 63, 1, 0, 0, 0, 0, 0, 8, 6);
    issue("R3", 9, 0, 19, 1, 1, 0, 1, 0, 100, 4, 2);
    // R5: count register source
    issue("R5", 4, 0, 0, 0, 1, 0, 1, 0, 5, 64, 1);
    issue("R5", 4, 0, 0, 0, 1, 0, 1, 0, 64'h100_0000_0000, 64, 1);
    issue("R9", 12, 0, 0, 0, 1, 0, 1, 0, 0, 64, 9);
    // R6: RA source, 64-bit compare
    issue("R6", 0, 3, 0, 0, 1, 0, 0, 10, 0, 32, 1);
    issue("R6", 7, 3, 0, 0, 1, 0, 1, 10, 0, 32, 1);
    issue("R6", 7, 3, 0, 0, 1, 0, 1, 64'h1_0000_0005, 0, 32, 1);
    issue("R6", 7, 3, 0, 0, 1, 0, 1, 40, 0, 40, 1);
    // R7: query and max-only forms
    issue("R7", 5, 0, 0, 0, 0, 0, 1, 0, 0, 20, 9);
    issue("R7", 5, 0, 0, 0, 0, 0, 1, 0, 0, 20, 0);
    issue("R7", 5, 0, 10, 1, 0, 0, 0, 0, 0, 20, 9);
    // R8: vertical-first flag both ways
    issue("R8", 0, 0, 3, 0, 1, 1, 0, 0, 0, 16, 0);
    issue("R8", 0, 0, 3, 0, 1, 0, 0, 0, 0, 16, 0);
    // R10: high RT index, long write-back
    issue("R10", 31, 2, 0, 0, 1, 0, 0, 200, 0, 255, 0);
    // R1: foreign opcode / extended opcode ignored
    issue("R1", 6, 0, 5, 1, 1, 1, 1, 0, 3, 10, 10, 21, 27);
    issue("R1", 6, 0, 5, 1, 1, 1, 1, 0, 3, 10, 10, 22, 26);
    idle("R1");

    finished = 1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end
endmodule